// File: doc/BRIEF.md
# Zero-Suppressed Multi-Trigger Readout Buffer

This block sits on a 32-channel digitizer card between the per-channel conversion logic and the host bus. On every level-1 trigger it captures the hit flags and the 16-bit result of each channel. It then builds a framed event record in a 32-bit word buffer. A record starts with a header word that carries the trigger number. One word follows for each channel that fired, and a tail word closes the record. Channels that did not fire take no space.

Records from many triggers build up before the host is told about them. Software writes a trigger-count threshold. When that many records have completed, the block raises a data-ready level and an interrupt. It also latches the number of buffered words, so the host can program one block transfer of exactly that length. The host pulls words through a first-word-fall-through read port. Once the last word of the block has been read, the interrupt drops.

A trigger that arrives while an earlier record is still being packed waits in a short trigger queue. A trigger is refused if the buffer could not take a worst-case record. The block counts each refused trigger and sets a sticky overflow flag.

Top module: `zs_readout_buf`

## Requirements
- R1: After reset, data_ready_o, irq_o and overflow_o are low, and drop_cnt_o and block_words_o are zero.
- R2: A header word has 4'hA in bits [31:28], zero in [27:16] and the trigger number in [15:0]. Trigger numbers start at 0 after reset and advance by one for every trigger pulse, whether it is accepted or refused.
- R3: A hit channel gives one word, with the channel number in bits [31:16] and its 16-bit result in [15:0]. Only channels whose hit bit is 1 appear. They appear in ascending channel order.
- R4: A tail word has 4'hF in bits [31:28], zero in [27:16] and, in [15:0], the record's total word count including its header and tail.
- R5: data_ready_o and irq_o rise once the number of records completed since the last block was armed reaches the threshold. A threshold of 0 acts as 1. block_words_o then equals the total word count of those records.
- R6: data_ready_o and irq_o stay high, and block_words_o stays unchanged, until exactly block_words_o words have been read. Both fall after the last of those reads.
- R7: rd_en_i is ignored while data_ready_o is low. No word is removed from the buffer.
- R8: Triggers on consecutive cycles, up to the trigger queue depth, are all packed in arrival order, with consecutive trigger numbers.
- R9: A trigger is refused when the buffer space already reserved plus one worst-case record (channels + 2 words) would exceed the buffer depth, or when the trigger queue is full. A refused trigger sets overflow_o, which stays set until reset, and increments drop_cnt_o.
- R10: Records that complete while a block is being read belong to the next block. They arm it once the current block is drained and the threshold is met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig_i | input | 1 | Level-1 trigger strobe, one cycle per trigger |
| hit_i | input | NCH | Per-channel hit flags captured on the trigger |
| data_i | input | NCH*DW | Per-channel results, channel c at [c*DW +: DW] |
| thr_we_i | input | 1 | Write strobe for the trigger-count threshold |
| thr_i | input | THR_W | Threshold value |
| rd_en_i | input | 1 | Pop the current word (honoured only while data_ready_o is high) |
| rd_data_o | output | 32 | Word at the head of the buffer |
| data_ready_o | output | 1 | A block is ready for transfer |
| irq_o | output | 1 | Interrupt request, asserted together with data_ready_o |
| block_words_o | output | 16 | Word count of the armed block |
| overflow_o | output | 1 | Sticky flag: a trigger was refused |
| drop_cnt_o | output | 16 | Number of refused triggers |

## Verification
A record can finish packing in the same cycle that the host pops a word. The space accounting and the next block's length both depend on handling that case correctly. To provoke it, the bench arms a 68-word block and starts draining it. While the drain is running it fires two small triggers, so their header, body and tail writes land on cycles that also pop. The bench judges the result in two ways: every drained word must match the scoreboard in order, and the block that arms next must report exactly the summed length of the two late records.

// File: rtl/zsr_pkg.sv
package zsr_pkg;
   localparam int WORD_W = 32;
   localparam logic [3:0] HDR_TAG  = 4'hA;
   localparam logic [3:0] TAIL_TAG = 4'hF;

   typedef enum logic [1:0] {PK_IDLE, PK_HDR, PK_BODY} pk_state_e;

   function automatic logic [WORD_W-1:0] hdr_word(input logic [15:0] tn);
      return {HDR_TAG, 12'h000, tn};
   endfunction

   function automatic logic [WORD_W-1:0] tail_word(input logic [15:0] len);
      return {TAIL_TAG, 12'h000, len};
   endfunction
endpackage

// File: rtl/zsr_fifo.sv
module zsr_fifo #(
   parameter int W     = 32,
   parameter int DEPTH = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);
   localparam bit POW2 = (DEPTH == (1 << AW));

   initial begin : p_param_chk
      assert (DEPTH >= 2) else $error("zsr_fifo: DEPTH must be at least 2");
      assert (W >= 1) else $error("zsr_fifo: W must be positive");
   end

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wp_q, rp_q, wp_nx, rp_nx;
   logic [CW-1:0] cnt_q;

   generate
      if (POW2) begin : g_wrap_nat
         assign wp_nx = wp_q + 1'b1;
         assign rp_nx = rp_q + 1'b1;
      end else begin : g_wrap_cmp
         assign wp_nx = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
         assign rp_nx = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
   endgenerate

   assign empty = (cnt_q == '0);
   assign full  = (cnt_q == CW'(DEPTH));
   assign rdata = mem[rp_q];

   always_ff @(posedge clk) begin
      if (push) mem[wp_q] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (push) wp_q <= wp_nx;
         if (pop)  rp_q <= rp_nx;
         case ({push, pop})
            2'b10:   cnt_q <= cnt_q + 1'b1;
            2'b01:   cnt_q <= cnt_q - 1'b1;
            default: cnt_q <= cnt_q;
         endcase
      end
   end

   // R9: space reservation upstream must keep every queue from overrunning
   a_r9_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> !full);
   a_r9_no_underrun: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> !empty);
endmodule

// File: rtl/zsr_packer.sv
module zsr_packer
   import zsr_pkg::*;
#(
   parameter int NCH = 32,
   parameter int DW  = 16,
   parameter int TNW = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              job_valid,
   input  logic [TNW-1:0]    job_tn,
   input  logic [NCH-1:0]    job_hits,
   input  logic [NCH*DW-1:0] job_data,
   output logic              job_pop,
   output logic              wr_en,
   output logic [WORD_W-1:0] wr_data,
   output logic              rec_done,
   output logic [15:0]       rec_len
);
   localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1;

   pk_state_e         state_q;
   logic [NCH-1:0]    map_q;
   logic [NCH*DW-1:0] dat_q;
   logic [TNW-1:0]    tn_q;
   logic [15:0]       cnt_q;

   logic [NCH-1:0] lowest;
   logic [CHW-1:0] idx;
   logic [DW-1:0]  sel;
   logic           body_word;

   // isolate lowest set hit and encode its channel index
   always_comb begin
      lowest = map_q & (~map_q + 1'b1);
      idx    = '0;
      for (int i = 0; i < NCH; i++) begin
         if (lowest[i]) idx = idx | CHW'(i);
      end
      sel = dat_q[idx*DW +: DW];
   end

   assign body_word = (state_q == PK_BODY) && (map_q != '0);

   always_comb begin
      job_pop  = 1'b0;
      wr_en    = 1'b0;
      wr_data  = '0;
      rec_done = 1'b0;
      rec_len  = cnt_q + 16'd1;
      case (state_q)
         PK_IDLE: job_pop = job_valid;
         PK_HDR: begin
            wr_en   = 1'b1;
            wr_data = hdr_word(16'(tn_q));
         end
         PK_BODY: begin
            wr_en = 1'b1;
            if (body_word) begin
               wr_data = {16'(idx), 16'(sel)};
            end else begin
               wr_data  = tail_word(cnt_q + 16'd1);
               rec_done = 1'b1;
            end
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= PK_IDLE;
         map_q   <= '0;
         dat_q   <= '0;
         tn_q    <= '0;
         cnt_q   <= '0;
      end else begin
         case (state_q)
            PK_IDLE: if (job_valid) begin
               map_q   <= job_hits;
               dat_q   <= job_data;
               tn_q    <= job_tn;
               cnt_q   <= '0;
               state_q <= PK_HDR;
            end
            PK_HDR: begin
               cnt_q   <= 16'd1;
               state_q <= PK_BODY;
            end
            PK_BODY: begin
               if (body_word) begin
                  map_q <= map_q & ~lowest;
                  cnt_q <= cnt_q + 16'd1;
               end else begin
                  state_q <= PK_IDLE;
               end
            end
            default: state_q <= PK_IDLE;
         endcase
      end
   end

   // checker state: index of the previous channel word
   logic           prev_body_q;
   logic [CHW-1:0] prev_idx_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         prev_body_q <= 1'b0;
         prev_idx_q  <= '0;
      end else begin
         prev_body_q <= body_word;
         prev_idx_q  <= idx;
      end
   end

   // R3: channel words of one record leave in strictly ascending order
   a_r3_ascending: assert property (@(posedge clk) disable iff (!rst_n)
      (body_word && prev_body_q) |-> (idx > prev_idx_q));
   // R8: a queued job is only taken while nothing is being written
   a_r8_take_idle: assert property (@(posedge clk) disable iff (!rst_n)
      job_pop |-> !wr_en);
endmodule

// File: rtl/zs_readout_buf.sv
module zs_readout_buf
   import zsr_pkg::*;
#(
   parameter int NCH       = 32,
   parameter int DW        = 16,
   parameter int TNW       = 16,
   parameter int BUF_DEPTH = 256,
   parameter int TQ_DEPTH  = 4,
   parameter int THR_W     = 8,
   parameter int THR_RESET = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              trig_i,
   input  logic [NCH-1:0]    hit_i,
   input  logic [NCH*DW-1:0] data_i,
   input  logic              thr_we_i,
   input  logic [THR_W-1:0]  thr_i,
   input  logic              rd_en_i,
   output logic [31:0]       rd_data_o,
   output logic              data_ready_o,
   output logic              irq_o,
   output logic [15:0]       block_words_o,
   output logic              overflow_o,
   output logic [15:0]       drop_cnt_o
);
   localparam int REC_MAX = NCH + 2;
   localparam int BCW     = $clog2(BUF_DEPTH + 1) + 1;
   localparam int TQ_W    = TNW + NCH + NCH * DW;
   localparam logic [BCW-1:0] REC_MAX_B = BCW'(REC_MAX);
   localparam logic [BCW-1:0] DEPTH_B   = BCW'(BUF_DEPTH);

   initial begin : p_param_chk
      assert (BUF_DEPTH >= REC_MAX) else $error("buffer smaller than one record");
      assert (BUF_DEPTH < 65536) else $error("buffer too deep for 16-bit counts");
      assert (DW <= 16 && DW >= 1) else $error("DW must be 1..16");
      assert (TNW <= 16 && TNW >= 1) else $error("TNW must be 1..16");
      assert (NCH <= 65536 && NCH >= 2) else $error("NCH out of range");
      assert (THR_W <= 16) else $error("THR_W must be at most 16");
   end

   // ---------------- trigger capture ----------------
   logic [TNW-1:0]   tn_q;
   logic             tq_full, tq_empty, tq_pop, accept, room;
   logic [TQ_W-1:0]  tq_rdata;
   logic [BCW-1:0]   commit_q;
   logic             overflow_q;
   logic [15:0]      drop_q;

   assign room   = (commit_q + REC_MAX_B) <= DEPTH_B;
   assign accept = trig_i && !tq_full && room;

   zsr_fifo #(.W(TQ_W), .DEPTH(TQ_DEPTH)) u_tq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (accept),
      .wdata ({tn_q, hit_i, data_i}),
      .pop   (tq_pop),
      .rdata (tq_rdata),
      .empty (tq_empty),
      .full  (tq_full)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tn_q       <= '0;
         overflow_q <= 1'b0;
         drop_q     <= '0;
      end else if (trig_i) begin
         tn_q <= tn_q + 1'b1;
         if (!accept) begin
            overflow_q <= 1'b1;
            drop_q     <= drop_q + 16'd1;
         end
      end
   end

   // ---------------- record packing ----------------
   logic        wf_push, rec_done;
   logic [31:0] wf_wdata;
   logic [15:0] rec_len;

   zsr_packer #(.NCH(NCH), .DW(DW), .TNW(TNW)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .job_valid (!tq_empty),
      .job_tn    (tq_rdata[TQ_W-1 -: TNW]),
      .job_hits  (tq_rdata[NCH*DW +: NCH]),
      .job_data  (tq_rdata[NCH*DW-1:0]),
      .job_pop   (tq_pop),
      .wr_en     (wf_push),
      .wr_data   (wf_wdata),
      .rec_done  (rec_done),
      .rec_len   (rec_len)
   );

   // ---------------- word buffer ----------------
   logic armed_q, pop, wf_empty, wf_full;
   assign pop = rd_en_i && armed_q;

   zsr_fifo #(.W(32), .DEPTH(BUF_DEPTH)) u_wbuf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (wf_push),
      .wdata (wf_wdata),
      .pop   (pop),
      .rdata (rd_data_o),
      .empty (wf_empty),
      .full  (wf_full)
   );

   // reserved = stored words + worst case for every outstanding record
   logic [BCW-1:0] add_res, rel_res, pop_res;
   assign add_res = accept ? REC_MAX_B : '0;
   assign rel_res = rec_done ? (REC_MAX_B - BCW'(rec_len)) : '0;
   assign pop_res = pop ? BCW'(1) : '0;

   always_ff @(posedge clk) begin
      if (!rst_n) commit_q <= '0;
      else        commit_q <= commit_q + add_res - rel_res - pop_res;
   end

   // ---------------- block accounting ----------------
   logic [THR_W-1:0] thr_q;
   logic [15:0]      thr_eff, evt_acc_q, words_acc_q, blk_len_q, blk_rem_q;
   logic             arm_now;

   assign thr_eff = (thr_q == '0) ? 16'd1 : 16'(thr_q);
   assign arm_now = !armed_q && (evt_acc_q >= thr_eff);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         thr_q       <= THR_W'(THR_RESET);
         evt_acc_q   <= '0;
         words_acc_q <= '0;
         armed_q     <= 1'b0;
         blk_len_q   <= '0;
         blk_rem_q   <= '0;
      end else begin
         if (thr_we_i) thr_q <= thr_i;
         if (arm_now) begin
            armed_q     <= 1'b1;
            blk_len_q   <= words_acc_q;
            blk_rem_q   <= words_acc_q;
            evt_acc_q   <= rec_done ? 16'd1 : 16'd0;
            words_acc_q <= rec_done ? rec_len : 16'd0;
         end else if (rec_done) begin
            evt_acc_q   <= evt_acc_q + 16'd1;
            words_acc_q <= words_acc_q + rec_len;
         end
         if (pop) begin
            blk_rem_q <= blk_rem_q - 16'd1;
            if (blk_rem_q == 16'd1) armed_q <= 1'b0;
         end
      end
   end

   assign data_ready_o  = armed_q;
   assign irq_o         = armed_q;
   assign block_words_o = blk_len_q;
   assign overflow_o    = overflow_q;
   assign drop_cnt_o    = drop_q;

   // R6: ready only falls on a host read
   a_r6_fall_on_read: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(data_ready_o) |-> $past(rd_en_i));
   // R6: block length is frozen while ready
   a_r6_len_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (data_ready_o && $past(data_ready_o)) |-> $stable(block_words_o));
   // R6: an armed block always has words behind it
   a_r6_ready_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      data_ready_o |-> !wf_empty);
   // R9: reservation keeps the word buffer from overrunning
   a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      wf_push |-> !wf_full);
   // R9: overflow flag is sticky
   a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      $past(overflow_o) |-> overflow_o);
   // R9: drop counter only moves with overflow set
   a_r9_drop_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (drop_cnt_o != $past(drop_cnt_o)) |-> overflow_o);
   // R5: an armed block is never empty
   a_r5_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(data_ready_o) |-> (block_words_o != 16'd0));
endmodule

// File: tb/zs_readout_buf_tb.sv
module zs_readout_buf_tb;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         trig = 1'b0;
   logic [31:0]  hit = '0;
   logic [511:0] data = '0;
   logic         thr_we = 1'b0;
   logic [7:0]   thr = '0;
   logic         rd_en = 1'b0;
   logic [31:0]  rd_data;
   logic         data_ready, irq, overflow;
   logic [15:0]  block_words, drop_cnt;

   int nchk = 0;
   int nfail = 0;
   int tn = 0;
   logic [31:0] exp_q[$];

   always #4 clk = ~clk;

   zs_readout_buf u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .trig_i        (trig),
      .hit_i         (hit),
      .data_i        (data),
      .thr_we_i      (thr_we),
      .thr_i         (thr),
      .rd_en_i       (rd_en),
      .rd_data_o     (rd_data),
      .data_ready_o  (data_ready),
      .irq_o         (irq),
      .block_words_o (block_words),
      .overflow_o    (overflow),
      .drop_cnt_o    (drop_cnt)
   );

   task automatic chk(input bit ok, input string req, input longint act, input longint exp);
      nchk++;
      if (!ok) begin
         nfail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wait_cyc(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic set_thr(input logic [7:0] v);
      thr_we = 1'b1; thr = v;
      @(negedge clk);
      thr_we = 1'b0;
   endtask

   // driver: one trigger, expected words pushed when it is to be accepted
   task automatic fire(input logic [31:0] hits, input bit acc);
      logic [511:0] d;
      int n;
      for (int c = 0; c < 32; c++) d[c*16 +: 16] = 16'(tn * 37 + c * 11 + 5);
      if (acc) begin
         exp_q.push_back({4'hA, 12'h000, 16'(tn)});
         n = 0;
         for (int c = 0; c < 32; c++) begin
            if (hits[c]) begin
               exp_q.push_back({16'(c), d[c*16 +: 16]});
               n++;
            end
         end
         exp_q.push_back({4'hF, 12'h000, 16'(n + 2)});
      end
      trig = 1'b1; hit = hits; data = d;
      @(negedge clk);
      trig = 1'b0;
      tn++;
   endtask

   // monitor: pops the block and compares against the scoreboard
   task automatic drain(input int exp_len);
      int got;
      logic [31:0] e;
      got = 0;
      while (data_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6 word beyond scoreboard", rd_data, 0);
            break;
         end
         e = exp_q.pop_front();
         chk(rd_data === e, "R2 R3 R4 word content/order", rd_data, e);
         rd_en = 1'b1;
         @(negedge clk);
         got++;
      end
      rd_en = 1'b0;
      chk(got == exp_len, "R6 words read before ready fell", got, exp_len);
      chk(irq == 1'b0, "R6 irq low after block read", irq, 0);
   endtask

   initial begin : watchdog
      #(8 * 150000);
      nfail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end

   initial begin : main
      wait_cyc(5);
      // R1 reset state
      chk(data_ready == 1'b0, "R1 data_ready", data_ready, 0);
      chk(irq == 1'b0, "R1 irq", irq, 0);
      chk(overflow == 1'b0, "R1 overflow", overflow, 0);
      chk(drop_cnt == 16'd0, "R1 drop_cnt", drop_cnt, 0);
      chk(block_words == 16'd0, "R1 block_words", block_words, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // Phase A: threshold 3, empty/full/sparse records
      set_thr(8'd3);
      fire(32'h0000_0000, 1'b1); wait_cyc(40);
      fire(32'hFFFF_FFFF, 1'b1); wait_cyc(40);
      chk(data_ready == 1'b0, "R5 below threshold", data_ready, 0);
      // R7: reads while not ready must not remove the first header
      rd_en = 1'b1; wait_cyc(3); rd_en = 1'b0;
      chk(rd_data === 32'hA000_0000, "R7 head unchanged after ignored reads", rd_data, 32'hA000_0000);
      fire(32'h8000_0011, 1'b1); wait_cyc(40);
      chk(data_ready == 1'b1, "R5 ready at threshold", data_ready, 1);
      chk(irq == 1'b1, "R5 irq at threshold", irq, 1);
      chk(block_words == 16'd41, "R5 block length", block_words, 41);
      wait_cyc(5);
      chk(block_words == 16'd41 && irq, "R6 irq and length held", block_words, 41);
      drain(41);

      // Phase B: back-to-back burst queued (R8)
      set_thr(8'd4);
      fire(32'hA5A5_A5A5, 1'b1);
      fire(32'h0000_0000, 1'b1);
      fire(32'hFFFF_FFFF, 1'b1);
      fire(32'h8000_0001, 1'b1);
      wait_cyc(200);
      chk(drop_cnt == 16'd0, "R8 no trigger lost in burst", drop_cnt, 0);
      chk(data_ready == 1'b1, "R8 burst block ready", data_ready, 1);
      chk(block_words == 16'd58, "R8 burst block length", block_words, 58);
      drain(58);

      // Phase C: records completing while a block is read (R10)
      set_thr(8'd2);
      fire(32'hFFFF_FFFF, 1'b1); wait_cyc(40);
      fire(32'hFFFF_FFFF, 1'b1); wait_cyc(40);
      chk(block_words == 16'd68, "R10 first block length", block_words, 68);
      fork
         drain(68);
         begin
            wait_cyc(2);
            fire(32'hFFFF_0000, 1'b1);
            wait_cyc(25);
            fire(32'h0000_0005, 1'b1);
         end
      join
      wait_cyc(60);
      chk(data_ready == 1'b1, "R10 next block armed", data_ready, 1);
      chk(block_words == 16'd22, "R10 next block length", block_words, 22);
      drain(22);

      // Phase D: space refusal (R9) and threshold 0 (R5)
      set_thr(8'd15);
      for (int k = 0; k < 7; k++) begin
         fire(32'hFFFF_FFFF, 1'b1);
         wait_cyc(45);
      end
      chk(overflow == 1'b0, "R9 no overflow while space remains", overflow, 0);
      fire(32'hFFFF_FFFF, 1'b0); wait_cyc(45);
      fire(32'hFFFF_FFFF, 1'b0); wait_cyc(45);
      chk(overflow == 1'b1, "R9 overflow set", overflow, 1);
      chk(drop_cnt == 16'd2, "R9 drop count", drop_cnt, 2);
      chk(data_ready == 1'b0, "R5 seven records below threshold 15", data_ready, 0);
      set_thr(8'd0);
      wait_cyc(3);
      chk(data_ready == 1'b1, "R5 threshold zero acts as one", data_ready, 1);
      chk(block_words == 16'd238, "R5 block of seven full records", block_words, 238);
      drain(238);
      chk(overflow == 1'b1, "R9 overflow sticky", overflow, 1);
      chk(drop_cnt == 16'd2, "R9 drop count held", drop_cnt, 2);
      chk(exp_q.size() == 0, "R2 scoreboard empty", exp_q.size(), 0);

      $display("[TB] %0d tests run, %0d failed", nchk, nfail);
      $finish;
   end
endmodule